// File: doc/BRIEF.md
# CPU Clock Switch Controller

This block chooses the clock that paces the CPU. Two source clocks are modelled as one-cycle enable pulses in a single fast reference domain: a main clock and a slower subsystem clock. The block divides the chosen source down to a CPU strobe (`cpu_tick`). Each strobe marks the end of one machine cycle. The main clock can be divided by 64, 8 or 4. The subsystem clock is always divided by 4.

Software programs two small registers. The mode register holds a source-select bit and a main-oscillator-stop bit. The ratio register holds a two-bit divide code. A write never acts at once. The full register view is queued and then checked against the setting currently in force. An accepted change of source or ratio stays pending for a number of machine cycles that depends on the old and new setting. The old setting keeps pacing the CPU until that count ends. Some moves between the main and subsystem clocks are forbidden. Stopping and restarting the main oscillator must be done in steps, ordered against the source select.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the setting is main clock divided by 64 (`eff_sub`=0, `eff_ratio`=00). `main_osc_en` is 1, and `busy` and `sw_err` are 0. The mode and ratio registers reset to zero.
- R2: Ratio codes are 00 for divide by 64, 10 for divide by 8 and 11 for divide by 4, counted in main-clock pulses. Code 01 is never valid. On the subsystem clock the divide is 4 subsystem pulses and `eff_ratio` reads 11. `cpu_tick` is a one-cycle pulse, registered the cycle after the last source pulse of each machine cycle.
- R3: A write is captured at one edge and evaluated at the next edge, provided nothing is pending. An accepted change raises `busy` at that evaluation edge. It takes effect on the D-th `cpu_tick` after that edge. A pulse in the evaluation cycle itself does not count. Until then the old divide stays in force. `eff_sub`, `eff_ratio` and the fall of `busy` all update in the same cycle as the D-th pulse.
- R4: Between main ratios, D is as follows. From divide by 64 to either faster ratio, D is MC_SLOW_UP (default 1). From divide by 8 to either other ratio, D is MC_MID_ANY (default 8). From divide by 4 to either slower ratio, D is MC_FAST_DOWN (default 16).
- R5: A move from main divide by 4 to the subsystem clock, or back, uses D = MC_FX4_FXT (default 4).
- R6: A request is rejected in each of these cases: it carries code 01; it selects the subsystem clock while the main clock is not at divide by 4; it selects the subsystem clock with a code other than 11 or with the stop bit set; it leaves the subsystem clock with a code other than 11, with the stop bit set, or while the main oscillator is still stopped. A rejected request changes neither the setting nor the stop state, and sets the sticky `sw_err`.
- R7: On an accepted request, the stop bit is applied at the evaluation edge with no delay. `main_osc_en` is 0 only while the subsystem clock is in force and the stop bit is set. While the main clock is in force, the stop bit has no effect on `main_osc_en` or `cpu_tick`.
- R8: A write merges its register with the last written value of the other register. A write that arrives while a change is pending is held as the single next request, replacing any request already held. It is evaluated once the pending change completes.
- R9: An accepted request that keeps the same source and ratio does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fx_tick | input | 1 | Main clock enable pulse |
| fxt_tick | input | 1 | Subsystem clock enable pulse |
| wr_mode | input | 1 | Write strobe for the mode register |
| mode_sel | input | 1 | Written select bit, 1 = subsystem clock |
| mode_stop | input | 1 | Written main-oscillator stop bit |
| wr_ratio | input | 1 | Write strobe for the ratio register |
| ratio_code | input | 2 | Written divide code |
| cpu_tick | output | 1 | One-cycle CPU machine-cycle strobe |
| eff_sub | output | 1 | Source in force, 1 = subsystem clock |
| eff_ratio | output | 2 | Divide code in force |
| main_osc_en | output | 1 | Main oscillator run enable |
| busy | output | 1 | A change of source or ratio is pending |
| sw_err | output | 1 | Sticky flag for a rejected request |

## Verification
A wrong pending count, or a setting applied at the wrong time, shows up at the strobe spacing. The gap between `cpu_tick` pulses changes one machine cycle early or late, and `eff_ratio` flips away from the D-th pulse. Both are visible within one machine cycle of the mistake. A wrong legality decision shows in the cycle after evaluation: either `sw_err` rises where it should not, or `busy` rises where it should stay low. A lost or stale queued request appears after the pending change completes, as a second switch to the wrong ratio.

// File: rtl/clksw_pkg.sv
// Shared types and the request legality rule for the CPU clock switch.
// Assumes the ratio code map 00=/64, 10=/8, 11=/4, 01=invalid.
package clksw_pkg;

    typedef enum logic [1:0] {
        RATIO_SLOW = 2'b00,
        RATIO_BAD  = 2'b01,
        RATIO_MID  = 2'b10,
        RATIO_FAST = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   sel;
        logic   stop;
        ratio_e ratio;
    } clk_cfg_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Decide whether a requested view may follow the setting in force (R6)
    function automatic logic req_legal(input logic cur_sub, input ratio_e cur_ratio,
                                       input logic cur_stop, input clk_cfg_t t);
        logic ok;
        if (t.ratio == RATIO_BAD)
            ok = 1'b0;
        else if (!cur_sub && t.sel)
            ok = (cur_ratio == RATIO_FAST) && (t.ratio == RATIO_FAST) && !t.stop;
        else if (cur_sub && !t.sel)
            ok = (t.ratio == RATIO_FAST) && !t.stop && !cur_stop;
        else if (cur_sub && t.sel)
            ok = (t.ratio == RATIO_FAST);
        else
            ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/clksw_regfile.sv
// Software-visible mode and ratio registers plus the one-deep request slot.
// Each write merges with the last written value of the other register and
// replaces whatever request is waiting. Assumes take is only raised when the
// slot is valid.
module clksw_regfile
    import clksw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_mode,
    input  logic     mode_sel,
    input  logic     mode_stop,
    input  logic     wr_ratio,
    input  logic [1:0] ratio_code,
    input  logic     take,
    output logic     q_valid,
    output clk_cfg_t q_cfg
);

    clk_cfg_t view_q;
    clk_cfg_t view_n;
    logic     any_wr;

    // Merge this cycle's writes into the last written view
    always_comb begin
        view_n = view_q;
        if (wr_mode) begin
            view_n.sel  = mode_sel;
            view_n.stop = mode_stop;
        end
        if (wr_ratio)
            view_n.ratio = ratio_e'(ratio_code);
        any_wr = wr_mode | wr_ratio;
    end

    // Hold the written view
    always_ff @(posedge clk) begin
        if (!rst_n)
            view_q <= '{sel: 1'b0, stop: 1'b0, ratio: RATIO_SLOW};
        else if (any_wr)
            view_q <= view_n;
    end

    // Keep the latest request in the single slot until the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_cfg   <= '{sel: 1'b0, stop: 1'b0, ratio: RATIO_SLOW};
        end else if (any_wr) begin
            q_valid <= 1'b1;
            q_cfg   <= view_n;
        end else if (take) begin
            q_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/clksw_seq.sv
// Switch sequencer: checks each queued request against the setting in force,
// applies the stop bit at once, and defers a change of source or ratio by a
// machine-cycle count that depends on the old and new setting. Assumes mc_end
// pulses once at the end of every machine cycle of the setting in force, and
// that every delay parameter is at least 1.
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int MC_SLOW_UP   = 1,
    parameter int MC_MID_ANY   = 8,
    parameter int MC_FAST_DOWN = 16,
    parameter int MC_FX4_FXT   = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     q_valid,
    input  clk_cfg_t q_cfg,
    input  logic     mc_end,
    output logic     take,
    output logic     eff_sub,
    output ratio_e   eff_ratio,
    output logic     eff_stop,
    output logic     busy,
    output logic     err
);

    localparam int DMAX = imax(imax(MC_SLOW_UP, MC_MID_ANY), imax(MC_FAST_DOWN, MC_FX4_FXT));
    localparam int DW   = $clog2(DMAX + 1);

    logic          pend_q;
    logic          pend_sub_q;
    ratio_e        pend_ratio_q;
    logic [DW-1:0] mc_left_q;
    logic          legal;
    logic          changes;
    logic [DW-1:0] delay_n;
    ratio_e        tgt_ratio;

    // Evaluate the waiting request against the setting in force
    always_comb begin
        take      = q_valid & ~pend_q;
        legal     = req_legal(eff_sub, eff_ratio, eff_stop, q_cfg);
        changes   = (q_cfg.sel != eff_sub) || (!q_cfg.sel && (q_cfg.ratio != eff_ratio));
        tgt_ratio = q_cfg.sel ? RATIO_FAST : q_cfg.ratio;
    end

    // Look up the deferral in machine cycles of the old setting (R4, R5)
    always_comb begin
        if (eff_sub || q_cfg.sel)
            delay_n = DW'(MC_FX4_FXT);
        else begin
            case (eff_ratio)
                RATIO_SLOW: delay_n = DW'(MC_SLOW_UP);
                RATIO_MID:  delay_n = DW'(MC_MID_ANY);
                default:    delay_n = DW'(MC_FAST_DOWN);
            endcase
        end
    end

    // Accept, reject or complete switch requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_sub      <= 1'b0;
            eff_ratio    <= RATIO_SLOW;
            eff_stop     <= 1'b0;
            pend_q       <= 1'b0;
            pend_sub_q   <= 1'b0;
            pend_ratio_q <= RATIO_SLOW;
            mc_left_q    <= '0;
            err          <= 1'b0;
        end else if (take) begin
            if (!legal)
                err <= 1'b1;
            else begin
                eff_stop <= q_cfg.stop;
                if (changes) begin
                    pend_q       <= 1'b1;
                    pend_sub_q   <= q_cfg.sel;
                    pend_ratio_q <= tgt_ratio;
                    mc_left_q    <= delay_n;
                end
            end
        end else if (pend_q && mc_end) begin
            if (mc_left_q == DW'(1)) begin
                pend_q    <= 1'b0;
                eff_sub   <= pend_sub_q;
                eff_ratio <= pend_ratio_q;
            end else
                mc_left_q <= mc_left_q - DW'(1);
        end
    end

    assign busy = pend_q;

endmodule

// File: rtl/clksw_divider.sv
// Machine-cycle divider: counts pulses of the source in force and marks the
// last pulse of each machine cycle. Assumes the setting only changes at that
// last pulse, so the counter wraps to zero exactly when a new ratio begins.
module clksw_divider
    import clksw_pkg::*;
#(
    parameter int DIV_SLOW = 64,
    parameter int DIV_MID  = 8,
    parameter int DIV_FAST = 4,
    parameter int DIV_SUB  = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fx_tick,
    input  logic   fxt_tick,
    input  logic   main_run,
    input  logic   eff_sub,
    input  ratio_e eff_ratio,
    output logic   mc_end,
    output logic   cpu_tick
);

    localparam int DMAX = imax(imax(DIV_SLOW, DIV_MID), imax(DIV_FAST, DIV_SUB));
    localparam int CW   = $clog2(DMAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          src_tick;

    // Pick the source pulse and the terminal count of the setting in force
    always_comb begin
        src_tick = eff_sub ? fxt_tick : (fx_tick & main_run);
        if (eff_sub)
            last = CW'(DIV_SUB - 1);
        else begin
            case (eff_ratio)
                RATIO_MID:  last = CW'(DIV_MID - 1);
                RATIO_FAST: last = CW'(DIV_FAST - 1);
                default:    last = CW'(DIV_SLOW - 1);
            endcase
        end
        mc_end = src_tick && (cnt_q == last);
    end

    // Count source pulses within the machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (src_tick)
            cnt_q <= mc_end ? '0 : cnt_q + CW'(1);
    end

    // Register the machine-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_tick <= 1'b0;
        else
            cpu_tick <= mc_end;
    end

endmodule

// File: rtl/cpu_clk_switch.sv
// CPU clock switch controller top. Ties the register file, the switch
// sequencer and the divider together, and drives the main oscillator enable.
// Assumes both source clocks arrive as enable pulses in the clk domain.
module cpu_clk_switch
    import clksw_pkg::*;
#(
    parameter int DIV_SLOW     = 64,
    parameter int DIV_MID      = 8,
    parameter int DIV_FAST     = 4,
    parameter int DIV_SUB      = 4,
    parameter int MC_SLOW_UP   = 1,
    parameter int MC_MID_ANY   = 8,
    parameter int MC_FAST_DOWN = 16,
    parameter int MC_FX4_FXT   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fx_tick,
    input  logic       fxt_tick,
    input  logic       wr_mode,
    input  logic       mode_sel,
    input  logic       mode_stop,
    input  logic       wr_ratio,
    input  logic [1:0] ratio_code,
    output logic       cpu_tick,
    output logic       eff_sub,
    output logic [1:0] eff_ratio,
    output logic       main_osc_en,
    output logic       busy,
    output logic       sw_err
);

    logic     q_valid;
    clk_cfg_t q_cfg;
    logic     take;
    logic     mc_end;
    logic     eff_stop;
    ratio_e   ratio_w;

    clksw_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_mode(wr_mode), .mode_sel(mode_sel), .mode_stop(mode_stop),
        .wr_ratio(wr_ratio), .ratio_code(ratio_code),
        .take(take), .q_valid(q_valid), .q_cfg(q_cfg)
    );

    clksw_seq #(
        .MC_SLOW_UP(MC_SLOW_UP), .MC_MID_ANY(MC_MID_ANY),
        .MC_FAST_DOWN(MC_FAST_DOWN), .MC_FX4_FXT(MC_FX4_FXT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_cfg(q_cfg), .mc_end(mc_end),
        .take(take), .eff_sub(eff_sub), .eff_ratio(ratio_w),
        .eff_stop(eff_stop), .busy(busy), .err(sw_err)
    );

    // The main oscillator halts only when the subsystem clock is in force
    assign main_osc_en = ~(eff_sub & eff_stop);
    assign eff_ratio   = ratio_w;

    clksw_divider #(
        .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID),
        .DIV_FAST(DIV_FAST), .DIV_SUB(DIV_SUB)
    ) u_div (
        .clk(clk), .rst_n(rst_n),
        .fx_tick(fx_tick), .fxt_tick(fxt_tick), .main_run(main_osc_en),
        .eff_sub(eff_sub), .eff_ratio(ratio_w),
        .mc_end(mc_end), .cpu_tick(cpu_tick)
    );

endmodule

// File: rtl/clksw_checker.sv
// Port-level protocol checks for the CPU clock switch, bound to the top.
module clksw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_tick,
    input logic       eff_sub,
    input logic [1:0] eff_ratio,
    input logic       main_osc_en,
    input logic       busy,
    input logic       sw_err
);

    // A pending switch ends only at a machine-cycle strobe
    assert_busy_ends_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cpu_tick);

    // The setting in force moves only at a strobe that closes a pending switch
    assert_setting_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(eff_sub) || !$stable(eff_ratio)) |-> (cpu_tick && $past(busy)));

    // The subsystem clock always reports divide by 4
    assert_sub_reads_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eff_sub |-> (eff_ratio == 2'b11));

    // Machine cycles last at least two reference cycles
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tick |=> !cpu_tick);

    // The invalid code never becomes the setting in force
    assert_no_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_ratio != 2'b01);

    // The subsystem clock is entered only from main divide by 4
    assert_sub_entry_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eff_sub) |-> ($past(eff_ratio) == 2'b11));

    // Rejections stay flagged until reset
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err |=> sw_err);

    // The main oscillator is stopped only while the subsystem clock runs the CPU
    assert_osc_off_only_on_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_osc_en |-> eff_sub);

endmodule

bind cpu_clk_switch clksw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .eff_sub(eff_sub),
    .eff_ratio(eff_ratio), .main_osc_en(main_osc_en), .busy(busy), .sw_err(sw_err)
);

// File: tb/tb_cpu_clk_switch.sv
module tb_cpu_clk_switch;

    localparam int CLK_PERIOD = 10;
    localparam int FXT_EVERY  = 8;
    localparam int MC_FX4_FXT = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fx_tick = 1'b1;
    logic       fxt_tick = 1'b0;
    logic       wr_mode = 1'b0;
    logic       mode_sel = 1'b0;
    logic       mode_stop = 1'b0;
    logic       wr_ratio = 1'b0;
    logic [1:0] ratio_code = 2'b00;
    logic       cpu_tick;
    logic       eff_sub;
    logic [1:0] eff_ratio;
    logic       main_osc_en;
    logic       busy;
    logic       sw_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int fxt_cnt = 0;

    // Model state
    bit       m_sub, m_stop, m_err;
    bit [1:0] m_ratio;
    bit       v_sel, v_stop;
    bit [1:0] v_ratio;

    cpu_clk_switch #(.MC_FX4_FXT(MC_FX4_FXT)) dut (
        .clk(clk), .rst_n(rst_n), .fx_tick(fx_tick), .fxt_tick(fxt_tick),
        .wr_mode(wr_mode), .mode_sel(mode_sel), .mode_stop(mode_stop),
        .wr_ratio(wr_ratio), .ratio_code(ratio_code),
        .cpu_tick(cpu_tick), .eff_sub(eff_sub), .eff_ratio(eff_ratio),
        .main_osc_en(main_osc_en), .busy(busy), .sw_err(sw_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Subsystem clock: one pulse every FXT_EVERY reference cycles
    always @(negedge clk) begin
        fxt_cnt  = (fxt_cnt + 1) % FXT_EVERY;
        fxt_tick = (fxt_cnt == FXT_EVERY - 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_legal(input bit cs, input bit [1:0] cr, input bit cst,
                                   input bit ts, input bit tst, input bit [1:0] tr);
        if (tr == 2'b01) return 1'b0;
        if (!cs && ts)   return (cr == 2'b11) && (tr == 2'b11) && !tst;
        if (cs && !ts)   return (tr == 2'b11) && !tst && !cst;
        if (cs && ts)    return (tr == 2'b11);
        return 1'b1;
    endfunction

    function automatic int m_delay(input bit cs, input bit [1:0] cr, input bit ts);
        if (cs || ts) return MC_FX4_FXT;
        case (cr)
            2'b00:   return 1;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int m_period(input bit s, input bit [1:0] r);
        if (s) return 4 * FXT_EVERY;
        case (r)
            2'b00:   return 64;
            2'b10:   return 8;
            default: return 4;
        endcase
    endfunction

    task automatic next_strobe(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!cpu_tick && gap < 5000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_mode = 1'b0; wr_ratio = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sub = 0; m_stop = 0; m_err = 0; m_ratio = 2'b00;
        v_sel = 0; v_stop = 0; v_ratio = 2'b00;
    endtask

    // One request through a register write, checked to completion
    task automatic do_req(input bit kind, input bit s, input bit st, input bit [1:0] r);
        bit lg, chg;
        int d, op, np, gap, g0;
        string tg;
        if (kind == 0) begin v_sel = s; v_stop = st; end
        else v_ratio = r;
        lg  = m_legal(m_sub, m_ratio, m_stop, v_sel, v_stop, v_ratio);
        chg = lg && ((v_sel != m_sub) || (!v_sel && v_ratio != m_ratio));
        wr_mode = (kind == 0); mode_sel = s; mode_stop = st;
        wr_ratio = (kind == 1); ratio_code = r;
        @(negedge clk);
        wr_mode = 1'b0; wr_ratio = 1'b0;
        @(negedge clk);
        if (!lg) begin
            m_err = 1'b1;
            chk(sw_err == 1'b1, "R6", "rejected request flag", sw_err, 1);
            chk(busy == 1'b0, "R6", "rejected request busy", busy, 0);
            chk(eff_sub == m_sub, "R6", "source after reject", eff_sub, m_sub);
            chk(eff_ratio == m_ratio, "R6", "ratio after reject", eff_ratio, m_ratio);
            chk(main_osc_en == !(m_sub && m_stop), "R6", "stop state after reject",
                main_osc_en, !(m_sub && m_stop));
        end else begin
            m_stop = v_stop;
            chk(main_osc_en == !(m_sub && m_stop), "R7", "oscillator enable",
                main_osc_en, !(m_sub && m_stop));
            if (!chg)
                chk(busy == 1'b0, "R9", "busy on unchanged setting", busy, 0);
            else begin
                chk(busy == 1'b1, "R3", "busy on accept", busy, 1);
                d  = m_delay(m_sub, m_ratio, v_sel);
                op = m_period(m_sub, m_ratio);
                tg = (m_sub || v_sel) ? "R5" : "R4";
                for (int n = 1; n <= d; n++) begin
                    next_strobe(gap);
                    if (n > 1)
                        chk(gap == op, "R3", "old period while pending", gap, op);
                    if (n < d) begin
                        chk(busy == 1'b1, "R3", "busy while pending", busy, 1);
                        chk(eff_ratio == m_ratio, tg, "early ratio", eff_ratio, m_ratio);
                        chk(eff_sub == m_sub, tg, "early source", eff_sub, m_sub);
                    end else begin
                        chk(busy == 1'b0, "R3", "busy at last strobe", busy, 0);
                        chk(eff_sub == v_sel, tg, "source at last strobe", eff_sub, v_sel);
                        chk(eff_ratio == (v_sel ? 2'b11 : v_ratio), tg, "ratio at last strobe",
                            eff_ratio, v_sel ? 2'b11 : v_ratio);
                    end
                end
                m_sub = v_sel; m_ratio = v_sel ? 2'b11 : v_ratio;
                np = m_period(m_sub, m_ratio);
                if (m_sub) next_strobe(g0);
                next_strobe(gap);
                chk(gap == np, "R2", "new period", gap, np);
            end
        end
        chk(sw_err == m_err, "R6", "sticky error flag", sw_err, m_err);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int g, g2;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // R1 reset state and reset period
        chk(eff_sub == 0, "R1", "reset source", eff_sub, 0);
        chk(eff_ratio == 2'b00, "R1", "reset ratio", eff_ratio, 0);
        chk(main_osc_en == 1, "R1", "reset oscillator", main_osc_en, 1);
        chk(busy == 0, "R1", "reset busy", busy, 0);
        chk(sw_err == 0, "R1", "reset error", sw_err, 0);
        next_strobe(g); next_strobe(g2);
        chk(g2 == 64, "R1", "reset period", g2, 64);

        // R8 queue: /64->/8 pending, two writes while busy, last one wins
        do_reset();
        wr_ratio = 1; ratio_code = 2'b10; @(negedge clk); wr_ratio = 0;
        @(negedge clk);
        chk(busy == 1, "R8", "first request pending", busy, 1);
        wr_ratio = 1; ratio_code = 2'b11; @(negedge clk);
        ratio_code = 2'b00; @(negedge clk); wr_ratio = 0;
        next_strobe(g);
        chk(eff_ratio == 2'b10, "R8", "first switch ratio", eff_ratio, 2);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1, "R8", "queued request pending", busy, 1);
        for (int n = 1; n <= 8; n++) begin
            next_strobe(g);
            if (n > 1) chk(g == 8, "R4", "/8 period while pending", g, 8);
            chk(eff_ratio == (n < 8 ? 2'b10 : 2'b00), "R8", "queued ratio",
                eff_ratio, n < 8 ? 2 : 0);
        end
        m_ratio = 2'b00; v_ratio = 2'b00;
        next_strobe(g);
        chk(g == 64, "R2", "period after queued switch", g, 64);

        // R4/R5/R7 directed path through the subsystem clock
        do_req(1, 0, 0, 2'b10);
        do_req(1, 0, 0, 2'b11);
        do_req(1, 0, 0, 2'b00);
        do_req(1, 0, 0, 2'b11);
        do_req(1, 0, 0, 2'b11);
        do_req(0, 1, 0, 2'b00);
        do_req(0, 1, 1, 2'b00);
        do_req(0, 0, 1, 2'b00);

        // R7 stop on main has no effect; R6 sub from /64 rejected
        do_reset();
        do_req(0, 0, 1, 2'b00);
        next_strobe(g); next_strobe(g);
        chk(g == 64, "R7", "period with stop on main", g, 64);
        do_req(0, 1, 0, 2'b00);
        next_strobe(g); next_strobe(g);
        chk(g == 64, "R6", "period after rejected entry", g, 64);

        // R6 invalid code
        do_reset();
        do_req(1, 0, 0, 2'b01);

        // R5/R7 restart the oscillator and return to main
        do_reset();
        do_req(1, 0, 0, 2'b11);
        do_req(0, 1, 0, 2'b00);
        do_req(0, 1, 1, 2'b00);
        do_req(0, 1, 0, 2'b00);
        do_req(0, 0, 0, 2'b00);

        // Random requests from a fixed seed
        for (int i = 0; i < 60; i++) begin
            bit k, s, st;
            bit [1:0] r;
            int pick;
            k    = 1'($urandom % 2);
            s    = 1'($urandom % 2);
            st   = ($urandom % 4) == 0;
            pick = int'($urandom % 7);
            r    = (pick < 2) ? 2'b00 : (pick < 4) ? 2'b10 : (pick < 6) ? 2'b11 : 2'b01;
            do_req(k, s, st, r);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule